// File: doc/BRIEF.md
# Differential 8-PSK Unique-Word Search and Tribit Demapper

This block sits behind a differential phase detector that has already reduced each received symbol to a 3-bit phase-step index (0..7, in units of 45 degrees). A one-cycle burst-start pulse opens a new burst. The block then looks for a fixed 16-symbol synchronisation word in the early part of the burst. It compares one candidate alignment for each incoming symbol and accepts a small number of symbol errors.

After lock, every later step index is turned into a 3-bit Gray-coded tribit and shifted out one bit per clock. The first 24 bits that leave the block are marked as the length header, and a strobe shows where the header ends. If the search window runs out without a match, the block raises a no-sync flag and stays silent until the next burst-start pulse.

Top module: `d8psk_sync_demap`

## Requirements
- R1: After reset, and in the cycle after any `burstStart` pulse, `syncFound`, `noSync`, `bitValid` and `hdrDone` are all low. The search then restarts from candidate offset 0. This also applies to a burst that had already locked or failed.
- R2: The unique word is the step sequence 0,4,2,6,1,5,3,7,0,4,2,6,1,5,3,7. Candidate offset k covers the steps numbered k to k+15 since `burstStart`. Offset k is judged on the step that completes it. When a match is found, `syncFound` rises one clock edge after that step is accepted, and it stays high until the next `burstStart`.
- R3: A candidate is accepted when 2 or fewer of its 16 steps differ from the unique word. With 3 mismatches it is rejected.
- R4: The lowest acceptable offset wins. Every step index after the winning word, and no step index of the word itself, is demapped. This holds even when the word occurs again later.
- R5: Only offsets 0 to 63 are searched. If offset 63 fails, `noSync` rises one edge after the 79th step of the burst. From then on, no bits are emitted and `syncFound` stays low until the next `burstStart`.
- R6: After lock, step s is mapped to tribit s XOR (s>>1): steps 0..7 give 000,001,011,010,110,111,101,100. The tribit is sent most significant bit first on `bitData`, with `bitValid` high, during the three cycles that follow the edge at which the step was accepted. Steps must arrive at least 3 cycles apart.
- R7: The tribits for steps s and (s+1) mod 8 differ in exactly one bit, for every s in 0..7.
- R8: `hdrBit` is high with each of the first 24 emitted bits of a burst and low with every later bit. `hdrDone` pulses for exactly one cycle, in the cycle after the 24th bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| burstStart | input | 1 | One-cycle pulse that opens a new burst; a step in the same cycle is dropped |
| stepValid | input | 1 | Qualifies `stepIdx` for one cycle |
| stepIdx | input | 3 | Phase-step index, modulo 8 |
| syncFound | output | 1 | Unique word located in this burst |
| noSync | output | 1 | Search window exhausted without a match |
| bitValid | output | 1 | `bitData` carries a demapped bit |
| bitData | output | 1 | Serial tribit bit, most significant first |
| hdrBit | output | 1 | Current bit belongs to the 24-bit header |
| hdrDone | output | 1 | One-cycle strobe after the 24th header bit |

## Verification
A clean word at offset 0 is followed by all eight step values. This shows the exact lock cycle, the Gray table, the bit order, the single-bit neighbour property and the header boundary.

A word with two corrupted symbols behind a run of filler locks, while a word with three corrupted symbols does not. Together these separate the mismatch threshold from an exact match.

A word repeated three times shows that the earliest offset wins. The repeats must come out as data.

Words placed so they complete offset 63 or offset 64 show the edge of the search window. They also show where `noSync` fires, that no bits are emitted afterwards, and that `burstStart` clears a locked burst.

// File: rtl/d8psk_pkg.sv
package d8psk_pkg;

  typedef logic [2:0] step_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic shift;
    logic load;
  } ctlStrobes_t;

  // Gray conversion of a phase step into its tribit
  function automatic step_t grayMap(step_t s);
    return s ^ (s >> 1);
  endfunction

  // unique word entry k: three-bit reversal of k modulo 8
  function automatic step_t uwStep(int k);
    logic [2:0] b;
    b = 3'(k);
    return {b[0], b[1], b[2]};
  endfunction

endpackage

// File: rtl/d8psk_demap_dp.sv
module d8psk_demap_dp
  import d8psk_pkg::*;
#(
  parameter int UW_LEN   = 16,
  parameter int HDR_BITS = 24,
  parameter int MISS_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  step_t             stepIdx,
  output logic [MISS_W-1:0] missCnt,
  output logic              bitValid,
  output logic              bitData,
  output logic              hdrBit,
  output logic              hdrDone
);

  localparam int CNT_W = $clog2(HDR_BITS + 1);

  step_t [UW_LEN-1:0] shReg;
  logic  [UW_LEN-1:0] missVec;
  step_t              triReg;
  logic  [1:0]        bitsLeft;
  logic  [CNT_W-1:0]  bitCnt;

  // step history, oldest entry at index 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobes.clear) begin
      shReg <= '0;
    end else if (strobes.shift) begin
      for (int i = 0; i < UW_LEN - 1; i++) shReg[i] <= shReg[i+1];
      shReg[UW_LEN-1] <= stepIdx;
    end
  end

  // candidate window: history shifted by one with the incoming step appended
  for (genvar i = 0; i < UW_LEN; i++) begin : g_cmp
    localparam int SRC = (i < UW_LEN - 1) ? i + 1 : i;
    assign missVec[i] = (((i < UW_LEN - 1) ? shReg[SRC] : stepIdx) != uwStep(i));
  end

  always_comb begin
    missCnt = '0;
    for (int i = 0; i < UW_LEN; i++) missCnt = missCnt + MISS_W'(missVec[i]);
  end

  // tribit serializer and header counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      triReg   <= '0;
      bitsLeft <= '0;
      bitCnt   <= '0;
      hdrDone  <= 1'b0;
    end else if (strobes.clear) begin
      triReg   <= '0;
      bitsLeft <= '0;
      bitCnt   <= '0;
      hdrDone  <= 1'b0;
    end else begin
      hdrDone <= (bitsLeft != 2'd0) && (bitCnt == CNT_W'(HDR_BITS - 1));
      if ((bitsLeft != 2'd0) && (bitCnt < CNT_W'(HDR_BITS))) bitCnt <= bitCnt + 1'b1;
      if (strobes.load) begin
        triReg   <= grayMap(stepIdx);
        bitsLeft <= 2'd3;
      end else if (bitsLeft != 2'd0) begin
        triReg   <= {triReg[1:0], 1'b0};
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

  assign bitValid = (bitsLeft != 2'd0);
  assign bitData  = triReg[2];
  assign hdrBit   = bitValid && (bitCnt < CNT_W'(HDR_BITS));

  always_comb begin
    if (strobes.load) begin
      AST_GRAY_ONE_STEP: assert ($countones(grayMap(stepIdx) ^ grayMap(stepIdx + 3'd1)) == 1); // R7
    end
  end

  AST_BITS_NEED_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitValid) |-> $past(strobes.load)); // R6

  AST_HDR_AFTER_BIT: assert property (@(posedge clk) disable iff (!rstN)
    hdrDone |-> ($past(hdrBit) && !hdrBit)); // R8

endmodule

// File: rtl/d8psk_sync_ctl.sv
module d8psk_sync_ctl
  import d8psk_pkg::*;
#(
  parameter int UW_LEN     = 16,
  parameter int SEARCH_WIN = 64,
  parameter int MAX_MISS   = 2,
  parameter int MISS_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstStart,
  input  logic              stepValid,
  input  logic [MISS_W-1:0] missCnt,
  output ctlStrobes_t       strobes,
  output logic              syncFound,
  output logic              noSync
);

  localparam int STEP_CNT_W = $clog2(UW_LEN + SEARCH_WIN);
  localparam int LAST_CNT   = UW_LEN + SEARCH_WIN - 2;

  typedef enum logic [1:0] {SEARCH, LOCKED, FAILED} syncState_t;

  syncState_t            state;
  logic [STEP_CNT_W-1:0] stepCnt;
  logic                  windowFull;
  logic                  hit;

  assign windowFull = (stepCnt >= STEP_CNT_W'(UW_LEN - 1));

  always_comb begin
    strobes.clear = burstStart;
    strobes.shift = stepValid && !burstStart && (state == SEARCH);
    strobes.load  = stepValid && !burstStart && (state == LOCKED);
  end

  assign hit = strobes.shift && windowFull && (missCnt <= MISS_W'(MAX_MISS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEARCH;
      stepCnt <= '0;
    end else if (burstStart) begin
      state   <= SEARCH;
      stepCnt <= '0;
    end else if (strobes.shift) begin
      stepCnt <= stepCnt + 1'b1;
      if (hit) state <= LOCKED;
      else if (stepCnt == STEP_CNT_W'(LAST_CNT)) state <= FAILED;
    end
  end

  assign syncFound = (state == LOCKED);
  assign noSync    = (state == FAILED);

  AST_LOCK_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncFound) |-> ($past(stepCnt) >= STEP_CNT_W'(UW_LEN - 1))); // R2

  AST_LOCK_MISS_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncFound) |-> ($past(missCnt) <= MISS_W'(MAX_MISS))); // R3

  AST_LOCK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncFound) |-> ($past(stepCnt) <= STEP_CNT_W'(LAST_CNT))); // R5

  AST_FAIL_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noSync) |-> ($past(stepCnt) == STEP_CNT_W'(LAST_CNT))); // R5

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |=> (!syncFound && !noSync)); // R1

endmodule

// File: rtl/d8psk_sync_demap.sv
module d8psk_sync_demap
  import d8psk_pkg::*;
#(
  parameter int UW_LEN     = 16,
  parameter int SEARCH_WIN = 64,
  parameter int MAX_MISS   = 2,
  parameter int HDR_BITS   = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       burstStart,
  input  logic       stepValid,
  input  logic [2:0] stepIdx,
  output logic       syncFound,
  output logic       noSync,
  output logic       bitValid,
  output logic       bitData,
  output logic       hdrBit,
  output logic       hdrDone
);

  localparam int MISS_W = $clog2(UW_LEN + 1);

  ctlStrobes_t       strobes;
  logic [MISS_W-1:0] missCnt;

  d8psk_sync_ctl #(
    .UW_LEN(UW_LEN), .SEARCH_WIN(SEARCH_WIN), .MAX_MISS(MAX_MISS), .MISS_W(MISS_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .stepValid(stepValid),
    .missCnt(missCnt), .strobes(strobes), .syncFound(syncFound), .noSync(noSync)
  );

  d8psk_demap_dp #(
    .UW_LEN(UW_LEN), .HDR_BITS(HDR_BITS), .MISS_W(MISS_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .stepIdx(stepIdx), .missCnt(missCnt),
    .bitValid(bitValid), .bitData(bitData), .hdrBit(hdrBit), .hdrDone(hdrDone)
  );

  AST_NO_BITS_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> syncFound); // R5

endmodule

// File: tb/d8psk_sync_demap_tb_top.sv
module d8psk_sync_demap_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic burstStart = 1'b0;
  logic stepValid = 1'b0;
  logic [2:0] stepIdx = 3'd0;
  logic syncFound, noSync, bitValid, bitData, hdrBit, hdrDone;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  int rxBit [0:511];
  int rxHdr [0:511];
  int nBits = 0;
  int hdrAt = -1;
  int hdrPulses = 0;
  int dataSteps [0:63];
  int nData = 0;

  int uwTab [0:7] = '{0, 4, 2, 6, 1, 5, 3, 7};
  int grayTab [0:7] = '{0, 1, 3, 2, 6, 7, 5, 4};

  always #(CLK_PERIOD/2) clk = ~clk;

  d8psk_sync_demap dut_i (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .stepValid(stepValid),
    .stepIdx(stepIdx), .syncFound(syncFound), .noSync(noSync), .bitValid(bitValid),
    .bitData(bitData), .hdrBit(hdrBit), .hdrDone(hdrDone)
  );

  always @(negedge clk) begin
    if (hdrDone) begin
      hdrAt = nBits;
      hdrPulses++;
    end
    if (bitValid && nBits < 512) begin
      rxBit[nBits] = bitData;
      rxHdr[nBits] = hdrBit;
      nBits++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic newBurst();
    @(negedge clk) burstStart = 1'b1;
    @(negedge clk) burstStart = 1'b0;
    nBits = 0; hdrAt = -1; hdrPulses = 0; nData = 0;
  endtask

  task automatic sendStep(input int s);
    @(negedge clk);
    stepValid = 1'b1;
    stepIdx = 3'(s);
    @(negedge clk) stepValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sendData(input int s);
    dataSteps[nData] = s;
    nData++;
    sendStep(s);
  endtask

  // send unique word entries first..last, corrupting those flagged in mask
  task automatic sendUw(input int first, input int last, input logic [15:0] mask);
    for (int k = first; k <= last; k++)
      sendStep(mask[k] ? (uwTab[k % 8] ^ 4) : uwTab[k % 8]);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic checkData(input string req);
    chk({req, " bit count"}, nBits, nData * 3);
    for (int k = 0; k < nData * 3; k++)
      chk({req, " bit value"}, rxBit[k], (grayTab[dataSteps[k/3]] >> (2 - k % 3)) & 1);
  endtask

  task automatic t_reset();
    chk("R1 syncFound at reset", syncFound, 0);
    chk("R1 noSync at reset", noSync, 0);
    chk("R1 bitValid at reset", bitValid, 0);
    chk("R1 hdrDone at reset", hdrDone, 0);
  endtask

  task automatic t_exact();
    newBurst();
    sendUw(0, 14, 16'h0);
    chk("R2 no lock before 16th step", syncFound, 0);
    sendUw(15, 15, 16'h0);
    chk("R2 lock on exact word", syncFound, 1);
    for (int s = 0; s < 8; s++) sendData(s);
    sendData(3);
    idle(4);
    checkData("R6");
    chk("R2 noSync stays low", noSync, 0);
    for (int k = 0; k < 27; k++) chk("R8 header flag", rxHdr[k], (k < 24) ? 1 : 0);
    chk("R8 hdrDone position", hdrAt, 24);
    chk("R8 hdrDone single pulse", hdrPulses, 1);
    for (int s = 0; s < 8; s++) begin
      int a, b;
      a = rxBit[3*s] * 4 + rxBit[3*s+1] * 2 + rxBit[3*s+2];
      b = rxBit[3*((s+1)%8)] * 4 + rxBit[3*((s+1)%8)+1] * 2 + rxBit[3*((s+1)%8)+2];
      chk("R7 neighbour distance", $countones(a ^ b), 1);
    end
  endtask

  task automatic t_twoMiss();
    newBurst();
    for (int k = 0; k < 5; k++) sendStep(7);
    sendUw(0, 15, 16'h1008);
    chk("R3 two mismatches accepted", syncFound, 1);
    sendData(5); sendData(1); sendData(6);
    idle(4);
    checkData("R3");
  endtask

  task automatic t_threeMiss();
    newBurst();
    sendUw(0, 15, 16'h0007);
    chk("R3 three mismatches rejected", syncFound, 0);
    for (int k = 16; k < 78; k++) sendStep(7);
    chk("R5 no failure before step 79", noSync, 0);
    sendStep(7);
    chk("R5 noSync after step 79", noSync, 1);
    sendUw(0, 15, 16'h0);
    for (int k = 0; k < 4; k++) sendStep(2);
    idle(4);
    chk("R5 no bits after failure", nBits, 0);
    chk("R5 no lock after failure", syncFound, 0);
  endtask

  task automatic t_earliest();
    newBurst();
    sendUw(0, 15, 16'h0);
    for (int k = 0; k < 8; k++) sendData(uwTab[k]);
    idle(4);
    checkData("R4");
  endtask

  task automatic t_lateEdge();
    newBurst();
    for (int k = 0; k < 63; k++) sendStep(7);
    sendUw(0, 15, 16'h0);
    chk("R5 lock at offset 63", syncFound, 1);
    sendData(2); sendData(7);
    idle(4);
    checkData("R5");
    newBurst();
    chk("R1 burstStart clears lock", syncFound, 0);
    chk("R1 burstStart no bits", bitValid, 0);
    for (int k = 0; k < 64; k++) sendStep(7);
    sendUw(0, 15, 16'h0);
    chk("R5 offset 64 not searched", syncFound, 0);
    chk("R5 noSync at window end", noSync, 1);
    idle(4);
    chk("R5 silent after window end", nBits, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_exact();
    t_twoMiss();
    t_threeMiss();
    t_earliest();
    t_lateEdge();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule